// File: doc/BRIEF.md
# Plug and Play Card State Controller

This block is the card-side control logic of an auto-configuration interface for plug-in cards on a legacy expansion bus. The host reaches every card through two shared ports. A write to the address port selects a configuration register. A write to the write-data port then writes that register. The controller decodes these accesses and moves the card through four states: waiting for the unlock key, sleep, isolation and configured. It holds the card select number, the read-data port address, the chosen logical device number and a bank of memory and I/O base-address descriptors.

An external key detector signals when the unlock sequence has been seen. A separate isolation engine runs the serial identifier contest. This controller tells that engine when to start and when to rewind its data pointer. The engine reports back whether the card won or lost. The same wake command has different effects depending on the written value and on the card's state. A zero value pulls every card that has no select number into isolation. A nonzero value picks out one configured card and sends every other awake card back to sleep. Reset values for the descriptors and the read port come in as parameters.

Top module: `pnp_card_ctrl`

## Requirements
- R1: On reset, state_o is 0 (waiting for key), csn_o and ldn_o are 0, and the descriptors and read-port address take their parameter values.
- R2: In state 0, writes to both ports and reads are ignored. key_det_i moves the card to state 1 (sleep).
- R3: state_o encodes the states as 0 wait-for-key, 1 sleep, 2 isolation and 3 config. The write-data port acts on the register last selected through the address port. The register offsets are 00h read-port address, 03h wake, 06h select number and 07h logical device.
- R4: In state 1 with csn_o equal to 0, a wake write of 00h moves the card to state 2. In the first cycle of state 2, iso_start_o and ptr_reset_o are each high for exactly one cycle.
- R5: In state 1, a nonzero wake write equal to csn_o moves the card to state 3. It pulses ptr_reset_o and leaves iso_start_o low.
- R6: In state 2 or 3, a wake write whose value differs from csn_o returns the card to state 1. In state 1, a wake write that does not match csn_o has no effect.
- R7: In state 2, iso_done_i with iso_win_i low returns the card to state 1. With iso_win_i high, the card stays in state 2 and is marked as the winner.
- R8: In state 2, after a win, a write to offset 06h stores the value in csn_o and moves the card to state 3. Before a win, the write has no effect.
- R9: A write to offset 00h updates rd_port_o only in state 2.
- R10: A write to offset 07h updates ldn_o only in state 3.
- R11: Memory descriptor n sits at offset 40h+8n. Byte +0 holds base bits 23:16 and byte +1 holds bits 15:8. Bits 7:0 read as zero. Writes are accepted only in state 3.
- R12: I/O descriptor n sits at offset 60h+2n. Byte +0 holds base bits 15:8 and byte +1 holds bits 7:0. Writes are accepted only in state 3.
- R13: rdata_en_o equals rd_i in states 2 and 3 and is low otherwise. In states 2 and 3, rdata_o returns the selected register (offsets 00h, 06h, 07h and the descriptors), and 0 for any other offset. rdata_o is 0 whenever rdata_en_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous bus reset |
| addr_wr_i | input | 1 | Write strobe for the address port |
| wdata_wr_i | input | 1 | Write strobe for the write-data port |
| rd_i | input | 1 | Read strobe for the read-data port |
| data_i | input | 8 | Write data for either port |
| key_det_i | input | 1 | Unlock key recognised |
| iso_done_i | input | 1 | Isolation contest finished |
| iso_win_i | input | 1 | Isolation result: 1 won, 0 lost |
| rdata_o | output | 8 | Read data |
| rdata_en_o | output | 1 | Card drives read data |
| state_o | output | 2 | Card state |
| csn_o | output | 8 | Card select number |
| rd_port_o | output | 8 | Read-data port address |
| ldn_o | output | 8 | Selected logical device |
| iso_start_o | output | 1 | Start pulse for the isolation engine |
| ptr_reset_o | output | 1 | Rewind pulse for the identifier/resource pointer |
| mem_base_o | output | N_MEM*MEM_W | Memory base addresses, descriptor 0 in the low bits |
| io_base_o | output | N_IO*IO_W | I/O base addresses, descriptor 0 in the low bits |

## Verification
The hardest situation to reach is a card that is back in sleep after being configured and that must then ignore a zero wake. The stimulus gets there through a full chain. It first sends the key. It then wakes with 00h and loses one contest. It wakes again, wins the contest and assigns select number 1. After that it fills the descriptors, sends the card back to sleep with another wake and tries writes that must not take effect. The stimulus also writes the select number before the win and tries a mismatched wake from config. A behavioural model tracks every state and register and is compared on every cycle.

// File: rtl/pnp_pkg.sv
package pnp_pkg;
  typedef enum logic [1:0] {
    ST_WAIT_KEY = 2'd0,
    ST_SLEEP    = 2'd1,
    ST_ISO      = 2'd2,
    ST_CFG      = 2'd3
  } card_state_e;

  localparam logic [7:0] OFS_RD_PORT = 8'h00;
  localparam logic [7:0] OFS_WAKE    = 8'h03;
  localparam logic [7:0] OFS_CSN     = 8'h06;
  localparam logic [7:0] OFS_LDN     = 8'h07;
  localparam logic [7:0] OFS_MEM     = 8'h40;
  localparam logic [7:0] OFS_IO      = 8'h60;
  localparam int         MEM_STRIDE  = 8;
  localparam int         IO_STRIDE   = 2;
endpackage

// File: rtl/pnp_port_decode.sv
module pnp_port_decode
  import pnp_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  card_state_e state_i,
  input  logic        addr_wr_i,
  input  logic        wdata_wr_i,
  input  logic [7:0]  data_i,
  output logic [7:0]  addr_o,
  output logic        wake_wr_o,
  output logic        rdp_wr_o,
  output logic        csn_wr_o,
  output logic        ldn_wr_o,
  output logic        cfg_wr_o
);
  logic [7:0] addr_q;
  logic       awake;

  assign awake = (state_i != ST_WAIT_KEY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 addr_q <= '0;
    else if (addr_wr_i && awake) addr_q <= data_i;
  end

  assign addr_o    = addr_q;
  assign wake_wr_o = wdata_wr_i && awake && (addr_q == OFS_WAKE);
  assign rdp_wr_o  = wdata_wr_i && (state_i == ST_ISO) && (addr_q == OFS_RD_PORT);
  assign csn_wr_o  = wdata_wr_i && (state_i == ST_ISO) && (addr_q == OFS_CSN);
  assign ldn_wr_o  = wdata_wr_i && (state_i == ST_CFG) && (addr_q == OFS_LDN);
  assign cfg_wr_o  = wdata_wr_i && (state_i == ST_CFG);
endmodule

// File: rtl/pnp_state_fsm.sv
module pnp_state_fsm
  import pnp_pkg::*;
#(
  parameter logic [7:0] RD_PORT_RST = 8'h00
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        key_det_i,
  input  logic        iso_done_i,
  input  logic        iso_win_i,
  input  logic        wake_wr_i,
  input  logic        rdp_wr_i,
  input  logic        csn_wr_i,
  input  logic [7:0]  data_i,
  output card_state_e state_o,
  output logic [7:0]  csn_o,
  output logic [7:0]  rd_port_o,
  output logic        iso_start_o,
  output logic        ptr_reset_o
);
  card_state_e st_q, st_d;
  logic [7:0]  csn_q, csn_d, rdp_q;
  logic        won_q, won_d, start_q, start_d, ptr_q, ptr_d;

  always_comb begin
    st_d    = st_q;
    csn_d   = csn_q;
    won_d   = won_q;
    start_d = 1'b0;
    ptr_d   = 1'b0;
    unique case (st_q)
      ST_WAIT_KEY: if (key_det_i) st_d = ST_SLEEP;
      ST_SLEEP: begin
        if (wake_wr_i && data_i == csn_q) begin
          st_d    = (data_i == 8'h00) ? ST_ISO : ST_CFG;
          ptr_d   = 1'b1;
          start_d = (data_i == 8'h00);
        end
      end
      ST_ISO: begin
        if (wake_wr_i && data_i != csn_q) st_d = ST_SLEEP;
        else if (csn_wr_i && won_q) begin
          csn_d = data_i;
          st_d  = ST_CFG;
        end else if (iso_done_i) begin
          if (iso_win_i) won_d = 1'b1;
          else           st_d  = ST_SLEEP;
        end
      end
      ST_CFG: if (wake_wr_i && data_i != csn_q) st_d = ST_SLEEP;
      default: st_d = ST_WAIT_KEY;
    endcase
    // winner mark lives only while isolating
    if (st_d != ST_ISO) won_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_WAIT_KEY;
      csn_q   <= '0;
      won_q   <= 1'b0;
      start_q <= 1'b0;
      ptr_q   <= 1'b0;
      rdp_q   <= RD_PORT_RST;
    end else begin
      st_q    <= st_d;
      csn_q   <= csn_d;
      won_q   <= won_d;
      start_q <= start_d;
      ptr_q   <= ptr_d;
      if (rdp_wr_i) rdp_q <= data_i;
    end
  end

  assign state_o     = st_q;
  assign csn_o       = csn_q;
  assign rd_port_o   = rdp_q;
  assign iso_start_o = start_q;
  assign ptr_reset_o = ptr_q;
endmodule

// File: rtl/pnp_desc_bank.sv
module pnp_desc_bank
  import pnp_pkg::*;
#(
  parameter int                N_MEM   = 4,
  parameter int                N_IO    = 8,
  parameter int                MEM_W   = 24,
  parameter int                IO_W    = 16,
  parameter logic [MEM_W-1:0]  MEM_RST = '0,
  parameter logic [IO_W-1:0]   IO_RST  = '0
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cfg_wr_i,
  input  logic                    ldn_wr_i,
  input  logic [7:0]              addr_i,
  input  logic [7:0]              data_i,
  output logic [7:0]              ldn_o,
  output logic [N_MEM*MEM_W-1:0]  mem_base_o,
  output logic [N_IO*IO_W-1:0]    io_base_o,
  output logic [7:0]              rd_byte_o
);
  localparam int HI_W = MEM_W - 8;

  logic [7:0] ldn_q;
  logic [7:0] mem_rb [N_MEM];
  logic [7:0] io_rb  [N_IO];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ldn_q <= '0;
    else if (ldn_wr_i) ldn_q <= data_i;
  end
  assign ldn_o = ldn_q;

  for (genvar g = 0; g < N_MEM; g++) begin : g_mem
    localparam logic [7:0] A0 = OFS_MEM + 8'(g * MEM_STRIDE);
    localparam logic [7:0] A1 = A0 + 8'd1;
    logic [HI_W-1:0] hi_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) hi_q <= MEM_RST[MEM_W-1:8];
      else if (cfg_wr_i) begin
        if (addr_i == A0) hi_q[HI_W-1 -: 8] <= data_i;
        if (addr_i == A1) hi_q[7:0]         <= data_i;
      end
    end
    assign mem_base_o[g*MEM_W +: MEM_W] = {hi_q, 8'h00};
    assign mem_rb[g] = (addr_i == A0) ? hi_q[HI_W-1 -: 8] :
                       (addr_i == A1) ? hi_q[7:0] : 8'h00;
  end

  for (genvar g = 0; g < N_IO; g++) begin : g_io
    localparam logic [7:0] A0 = OFS_IO + 8'(g * IO_STRIDE);
    localparam logic [7:0] A1 = A0 + 8'd1;
    logic [IO_W-1:0] base_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) base_q <= IO_RST;
      else if (cfg_wr_i) begin
        if (addr_i == A0) base_q[IO_W-1 -: 8] <= data_i;
        if (addr_i == A1) base_q[7:0]         <= data_i;
      end
    end
    assign io_base_o[g*IO_W +: IO_W] = base_q;
    assign io_rb[g] = (addr_i == A0) ? base_q[IO_W-1 -: 8] :
                      (addr_i == A1) ? base_q[7:0] : 8'h00;
  end

  always_comb begin
    rd_byte_o = (addr_i == OFS_LDN) ? ldn_q : 8'h00;
    for (int i = 0; i < N_MEM; i++) rd_byte_o = rd_byte_o | mem_rb[i];
    for (int i = 0; i < N_IO; i++)  rd_byte_o = rd_byte_o | io_rb[i];
  end
endmodule

// File: rtl/pnp_card_ctrl.sv
module pnp_card_ctrl
  import pnp_pkg::*;
#(
  parameter int               N_MEM       = 4,
  parameter int               N_IO        = 8,
  parameter int               MEM_W       = 24,
  parameter int               IO_W        = 16,
  parameter logic [MEM_W-1:0] MEM_RST     = '0,
  parameter logic [IO_W-1:0]  IO_RST      = '0,
  parameter logic [7:0]       RD_PORT_RST = 8'h00
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   addr_wr_i,
  input  logic                   wdata_wr_i,
  input  logic                   rd_i,
  input  logic [7:0]             data_i,
  input  logic                   key_det_i,
  input  logic                   iso_done_i,
  input  logic                   iso_win_i,
  output logic [7:0]             rdata_o,
  output logic                   rdata_en_o,
  output logic [1:0]             state_o,
  output logic [7:0]             csn_o,
  output logic [7:0]             rd_port_o,
  output logic [7:0]             ldn_o,
  output logic                   iso_start_o,
  output logic                   ptr_reset_o,
  output logic [N_MEM*MEM_W-1:0] mem_base_o,
  output logic [N_IO*IO_W-1:0]   io_base_o
);
  card_state_e st;
  logic [7:0]  addr, bank_byte;
  logic        wake_wr, rdp_wr, csn_wr, ldn_wr, cfg_wr;

  pnp_port_decode u_dec (
    .clk_i, .rst_ni, .state_i(st), .addr_wr_i, .wdata_wr_i, .data_i,
    .addr_o(addr), .wake_wr_o(wake_wr), .rdp_wr_o(rdp_wr),
    .csn_wr_o(csn_wr), .ldn_wr_o(ldn_wr), .cfg_wr_o(cfg_wr)
  );

  pnp_state_fsm #(.RD_PORT_RST(RD_PORT_RST)) u_fsm (
    .clk_i, .rst_ni, .key_det_i, .iso_done_i, .iso_win_i,
    .wake_wr_i(wake_wr), .rdp_wr_i(rdp_wr), .csn_wr_i(csn_wr), .data_i,
    .state_o(st), .csn_o, .rd_port_o, .iso_start_o, .ptr_reset_o
  );

  pnp_desc_bank #(
    .N_MEM(N_MEM), .N_IO(N_IO), .MEM_W(MEM_W), .IO_W(IO_W),
    .MEM_RST(MEM_RST), .IO_RST(IO_RST)
  ) u_bank (
    .clk_i, .rst_ni, .cfg_wr_i(cfg_wr), .ldn_wr_i(ldn_wr),
    .addr_i(addr), .data_i, .ldn_o, .mem_base_o, .io_base_o,
    .rd_byte_o(bank_byte)
  );

  assign state_o    = st;
  assign rdata_en_o = rd_i && (st == ST_ISO || st == ST_CFG);

  always_comb begin
    rdata_o = 8'h00;
    if (rdata_en_o) begin
      if (addr == OFS_CSN)          rdata_o = csn_o;
      else if (addr == OFS_RD_PORT) rdata_o = rd_port_o;
      else                          rdata_o = bank_byte;
    end
  end
endmodule

// File: rtl/pnp_card_ctrl_chk.sv
module pnp_card_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       key_det_i,
  input logic       iso_done_i,
  input logic       iso_win_i,
  input logic       wdata_wr_i,
  input logic [1:0] state_o,
  input logic [7:0] csn_o,
  input logic [7:0] ldn_o,
  input logic       rdata_en_o,
  input logic       iso_start_o,
  input logic       ptr_reset_o
);
  p_wait_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd0 && !key_det_i) |=> state_o == 2'd0);

  p_start_iso_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iso_start_o |-> (state_o == 2'd2 && ptr_reset_o));

  p_lose_sleep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd2 && iso_done_i && !iso_win_i && !wdata_wr_i) |=> state_o == 2'd1);

  p_csn_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csn_o != $past(csn_o)) |-> ($past(state_o) == 2'd2 && $past(wdata_wr_i)));

  p_ldn_cfg_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ldn_o != $past(ldn_o)) |-> $past(state_o) == 2'd3);

  p_rd_quiet_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !state_o[1] |-> !rdata_en_o);
endmodule

bind pnp_card_ctrl pnp_card_ctrl_chk u_chk (.*);

// File: tb/pnp_card_ctrl_bench.sv
module pnp_card_ctrl_bench;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        addr_wr_i = 0, wdata_wr_i = 0, rd_i = 0;
  logic [7:0]  data_i = 0;
  logic        key_det_i = 0, iso_done_i = 0, iso_win_i = 0;
  logic [7:0]  rdata_o, csn_o, rd_port_o, ldn_o;
  logic        rdata_en_o, iso_start_o, ptr_reset_o;
  logic [1:0]  state_o;
  logic [95:0] mem_base_o;
  logic [127:0] io_base_o;

  int checks = 0, errors = 0;
  bit finished = 0;

  pnp_card_ctrl u_pnp_card_ctrl (.*);

  always #4 clk_i = ~clk_i;

  // behavioural reference
  int m_st, m_csn, m_won, m_addr, m_rdp, m_ldn, m_ist, m_pr;
  int m_mem [4];
  int m_io  [8];

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = 0; m_csn = 0; m_won = 0; m_addr = 0; m_rdp = 0; m_ldn = 0;
      m_ist = 0; m_pr = 0;
      foreach (m_mem[i]) m_mem[i] = 0;
      foreach (m_io[i])  m_io[i]  = 0;
    end else begin
      int d;
      d = int'(data_i);
      m_ist = 0; m_pr = 0;
      if (m_st == 0) begin
        if (key_det_i) m_st = 1;
      end else begin
        if (wdata_wr_i) begin
          if (m_addr == 3) begin
            if (m_st == 1 && d == m_csn) begin
              m_st = (d == 0) ? 2 : 3; m_pr = 1; m_ist = (d == 0);
            end else if (m_st >= 2 && d != m_csn) m_st = 1;
          end else if (m_addr == 0) begin
            if (m_st == 2) m_rdp = d;
          end else if (m_addr == 6) begin
            if (m_st == 2 && m_won == 1) begin m_csn = d; m_st = 3; end
          end else if (m_addr == 7) begin
            if (m_st == 3) m_ldn = d;
          end else if (m_st == 3) begin
            for (int n = 0; n < 4; n++) begin
              if (m_addr == 64 + 8*n) m_mem[n] = (m_mem[n] & 'h00ff00) | (d << 16);
              if (m_addr == 65 + 8*n) m_mem[n] = (m_mem[n] & 'hff0000) | (d << 8);
            end
            for (int n = 0; n < 8; n++) begin
              if (m_addr == 96 + 2*n) m_io[n] = (m_io[n] & 'h00ff) | (d << 8);
              if (m_addr == 97 + 2*n) m_io[n] = (m_io[n] & 'hff00) | d;
            end
          end
        end else if (m_st == 2 && iso_done_i) begin
          if (iso_win_i) m_won = 1; else m_st = 1;
        end
        if (addr_wr_i) m_addr = d;
      end
      if (m_st != 2) m_won = 0;
    end
  end

  function automatic int exp_rdata();
    int v;
    v = 0;
    if (!(rd_i && m_st >= 2)) return 0;
    if (m_addr == 6) v = m_csn;
    else if (m_addr == 7) v = m_ldn;
    else if (m_addr == 0) v = m_rdp;
    for (int n = 0; n < 4; n++) begin
      if (m_addr == 64 + 8*n) v = (m_mem[n] >> 16) & 255;
      if (m_addr == 65 + 8*n) v = (m_mem[n] >> 8) & 255;
    end
    for (int n = 0; n < 8; n++) begin
      if (m_addr == 96 + 2*n) v = (m_io[n] >> 8) & 255;
      if (m_addr == 97 + 2*n) v = m_io[n] & 255;
    end
    return v;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && !finished) begin
      check("R3 state", int'(state_o), m_st);
      check("R8 csn", int'(csn_o), m_csn);
      check("R10 ldn", int'(ldn_o), m_ldn);
      check("R9 rd_port", int'(rd_port_o), m_rdp);
      check("R4 iso_start", int'(iso_start_o), m_ist);
      check("R5 ptr_reset", int'(ptr_reset_o), m_pr);
      check("R13 rdata_en", int'(rdata_en_o), int'(rd_i && m_st >= 2));
      check("R13 rdata", int'(rdata_o), exp_rdata());
      for (int n = 0; n < 4; n++) check("R11 mem_base", int'(mem_base_o[n*24 +: 24]), m_mem[n]);
      for (int n = 0; n < 8; n++) check("R12 io_base", int'(io_base_o[n*16 +: 16]), m_io[n]);
    end
  end

  task automatic op(bit aw, bit ww, bit rd, logic [7:0] d, bit key, bit done, bit win);
    @(posedge clk_i); #2;
    addr_wr_i = aw; wdata_wr_i = ww; rd_i = rd; data_i = d;
    key_det_i = key; iso_done_i = done; iso_win_i = win;
  endtask
  task automatic idle();                       op(0, 0, 0, 8'h00, 0, 0, 0); endtask
  task automatic set_addr(logic [7:0] a);      op(1, 0, 0, a, 0, 0, 0); endtask
  task automatic wr_reg(logic [7:0] a, logic [7:0] v);
    set_addr(a); op(0, 1, 0, v, 0, 0, 0);
  endtask
  task automatic rd_reg(logic [7:0] a);        set_addr(a); op(0, 0, 1, 8'h00, 0, 0, 0); endtask
  task automatic settle();                     idle(); @(negedge clk_i); endtask

  task automatic do_reset();
    @(posedge clk_i); #2; rst_ni = 0;
    addr_wr_i = 0; wdata_wr_i = 0; rd_i = 0; key_det_i = 0; iso_done_i = 0; iso_win_i = 0;
    repeat (2) @(posedge clk_i); #2; rst_ni = 1;
    @(negedge clk_i);
    check("R1 state", int'(state_o), 0);
    check("R1 csn", int'(csn_o), 0);
    check("R1 ldn", int'(ldn_o), 0);
    check("R1 mem", int'(mem_base_o[23:0]), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      finished = 1; errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R2: locked card ignores everything
    wr_reg(8'h03, 8'h00);
    rd_reg(8'h06);
    settle();
    check("R2 locked", int'(state_o), 0);
    op(0, 0, 0, 8'h00, 1, 0, 0);
    settle();
    check("R2 key", int'(state_o), 1);
    // R6: non-matching wake in sleep
    wr_reg(8'h03, 8'h05);
    settle();
    check("R6 sleep hold", int'(state_o), 1);
    // R4: wake zero
    wr_reg(8'h03, 8'h00);
    settle();
    check("R4 iso", int'(state_o), 2);
    wr_reg(8'h00, 8'h83);
    rd_reg(8'h00);
    wr_reg(8'h06, 8'h07); // before win: ignored (R8)
    settle();
    check("R8 no win", int'(csn_o), 0);
    // R7: lose
    op(0, 0, 0, 8'h00, 0, 1, 0);
    settle();
    check("R7 lose", int'(state_o), 1);
    wr_reg(8'h03, 8'h00);
    op(0, 0, 0, 8'h00, 0, 1, 1);
    settle();
    check("R7 win", int'(state_o), 2);
    wr_reg(8'h06, 8'h01);
    settle();
    check("R8 cfg", int'(state_o), 3);
    wr_reg(8'h07, 8'h02);
    for (int n = 0; n < 4; n++) begin
      wr_reg(8'(64 + 8*n), 8'(8'h10 + n));
      wr_reg(8'(65 + 8*n), 8'(8'h20 + n));
    end
    for (int n = 0; n < 8; n++) begin
      wr_reg(8'(96 + 2*n), 8'(8'h30 + n));
      wr_reg(8'(97 + 2*n), 8'(8'h40 + n));
    end
    rd_reg(8'h06); rd_reg(8'h07); rd_reg(8'h00); rd_reg(8'h20);
    for (int n = 0; n < 4; n++) begin rd_reg(8'(64 + 8*n)); rd_reg(8'(65 + 8*n)); end
    for (int n = 0; n < 8; n++) begin rd_reg(8'(96 + 2*n)); rd_reg(8'(97 + 2*n)); end
    settle();
    check("R11 mem3", int'(mem_base_o[72 +: 24]), 24'h132300);
    check("R12 io7", int'(io_base_o[112 +: 16]), 16'h3747);
    // R6: mismatched wake from config
    wr_reg(8'h03, 8'h00);
    settle();
    check("R6 cfg to sleep", int'(state_o), 1);
    rd_reg(8'h06);
    wr_reg(8'h07, 8'h09);
    wr_reg(8'h40, 8'hff);
    wr_reg(8'h61, 8'hff);
    wr_reg(8'h00, 8'h11);
    wr_reg(8'h03, 8'h00); // csn set: zero wake ignored
    settle();
    check("R10 ldn hold", int'(ldn_o), 2);
    check("R4 no rewake", int'(state_o), 1);
    // R5: matching wake
    wr_reg(8'h03, 8'h01);
    settle();
    check("R5 cfg", int'(state_o), 3);
    wr_reg(8'h03, 8'h02);
    settle();
    check("R6 other csn", int'(state_o), 1);
    wr_reg(8'h03, 8'h01);
    rd_reg(8'h41);
    settle();
    do_reset();
    settle();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule